// File: doc/BRIEF.md
# Combinational Restoring Array Divider

This block divides an unsigned N-bit dividend by an unsigned M-bit divisor (M < N) in a single combinational evaluation. It has no clock, no state and no handshake. A new quotient and remainder follow every change at its inputs after the array settles.

The array is a stack of subtraction rows built from full-subtracter cells. The top row lines the divisor up under the most significant end of the dividend. Each row below shifts it one place toward the least significant end. A row subtracts the divisor from an (M+1)-bit window of the running partial remainder. When the row's top borrow is clear, the difference moves on as the new window. When the borrow is set, a multiplexer in every cell passes the old window through unchanged. Each row's quotient bit is the inverse of its top borrow.

There are N−M+1 rows, so the quotient is N−M+1 bits wide. The result is exact for every dividend whose quotient fits that width. A divisor with its top bit set always satisfies this.

Top module: `restore_div_array`

## Requirements
- R1: The quotient output is N−M+1 bits wide. Its bit N−M comes from the top row and bit 0 from the bottom row. For a nonzero divisor D and a dividend A with (A >> (N−M+1)) < D, it equals A / D.
- R2: Under the same conditions as R1, the N-bit remainder output equals A mod D.
- R3: A row whose top borrow is 0 passes on its window minus the divisor. Its quotient bit is 1. The top borrow is 1 exactly when the window is less than the divisor.
- R4: A row whose top borrow is 1 passes its window on unchanged. Its quotient bit is 0.
- R5: A zero divisor gives a quotient of all ones and a remainder equal to the dividend.
- R6: With N=5 and M=3, dividend 17 and divisor 3 give quotient 5 and remainder 2.
- R7: With N=5 and M=3, dividend 27 and divisor 4 give quotient 6 and remainder 3.
- R8: Under the conditions of R1, the remainder is strictly less than the divisor.
- R9: A divisor with its bit M−1 set gives the exact quotient and remainder for every dividend.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dvd_i | input | N | Unsigned dividend |
| dvs_i | input | M | Unsigned divisor |
| quo_o | output | N−M+1 | Quotient, one bit per row, top row at the MSB |
| rem_o | output | N | Remainder after the bottom row |

## Verification
The narrow configuration is swept over every dividend and divisor pair.

- **Zero divisor.** A wrong design would fall out of the restore path and give something other than all ones with the dividend passed through.
- **Borrow polarity in a row.** If a row took the difference on a set borrow, or passed the window on a clear one, the quotient bits would flip and the remainder would pick up wrapped values at or above the divisor.
- **Divisor with its top bit set.** This exercises the largest quotients, where a mis-aligned first row or a dropped implicit leading zero would lose the top quotient bit.
- **Wider configuration.** Pseudo-random pairs in the valid range catch window indexing that only goes wrong when N−M is larger.

// File: rtl/restore_div_pkg.sv
package restore_div_pkg;

  // Number of subtraction rows (and quotient bits) for an N/M array.
  function automatic int unsigned row_count(input int unsigned n, input int unsigned m);
    return n - m + 1;
  endfunction

endpackage

// File: rtl/restore_div_cell.sv
module restore_div_cell (
  input  logic min_i,    // minuend bit
  input  logic sub_i,    // subtrahend bit
  input  logic bin_i,    // borrow in from the less significant cell
  input  logic keep_i,   // row top borrow: 1 keeps the minuend
  output logic bout_o,   // borrow out to the more significant cell
  output logic res_o     // selected result bit
);

  logic diff;

  always_comb begin
    diff   = min_i ^ sub_i ^ bin_i;
    bout_o = (~min_i & sub_i) | (~(min_i ^ sub_i) & bin_i);
    res_o  = keep_i ? min_i : diff;
  end

endmodule

// File: rtl/restore_div_row.sv
module restore_div_row #(
  parameter int unsigned M = 3
) (
  input  logic [M:0]   win_i,   // M+1 bit window of the partial remainder
  input  logic [M-1:0] dvs_i,   // divisor
  output logic [M:0]   win_o,   // window passed to the next row
  output logic         qbit_o   // quotient bit of this row
);

  localparam int unsigned W = M + 1;

  logic [W:0]   chain;
  logic         top_borrow;

  assign chain[0]   = 1'b0;
  assign top_borrow = chain[W];
  assign qbit_o     = ~top_borrow;

  for (genvar k = 0; k < W; k++) begin : g_cell
    logic sub_bit;
    if (k < M) begin : g_dvs
      assign sub_bit = dvs_i[k];
    end else begin : g_pad
      assign sub_bit = 1'b0;
    end

    restore_div_cell u_cell (
      .min_i  (win_i[k]),
      .sub_i  (sub_bit),
      .bin_i  (chain[k]),
      .keep_i (top_borrow),
      .bout_o (chain[k+1]),
      .res_o  (win_o[k])
    );
  end

  always_comb begin
    // R3
    borrow_match_chk: assert (top_borrow == (win_i < {1'b0, dvs_i}))
      else $error("row borrow disagrees with window compare");
    if (!top_borrow) begin
      // R3
      take_diff_chk: assert (win_o == win_i - {1'b0, dvs_i})
        else $error("row did not pass on its difference");
    end else begin
      // R4
      restore_chk: assert (win_o == win_i)
        else $error("row did not restore its minuend");
    end
  end

endmodule

// File: rtl/restore_div_array.sv
module restore_div_array
  import restore_div_pkg::*;
#(
  parameter int unsigned N = 8,
  parameter int unsigned M = 4
) (
  input  logic [N-1:0]                      dvd_i,
  input  logic [M-1:0]                      dvs_i,
  output logic [row_count(N, M)-1:0]        quo_o,
  output logic [N-1:0]                      rem_o
);

  localparam int unsigned Q = row_count(N, M);

  // Partial remainder entering each row, one guard bit above the dividend.
  logic [Q:0][N:0] pr;

  assign pr[0] = {1'b0, dvd_i};

  for (genvar r = 0; r < Q; r++) begin : g_row
    localparam int unsigned LO = N - M - r;
    logic [M:0] w_in;
    logic [M:0] w_out;
    logic [N:0] nxt;

    assign w_in = pr[r][LO +: M+1];

    restore_div_row #(.M(M)) u_row (
      .win_i  (w_in),
      .dvs_i  (dvs_i),
      .win_o  (w_out),
      .qbit_o (quo_o[Q-1-r])
    );

    always_comb begin
      nxt            = pr[r];
      nxt[LO +: M+1] = w_out;
    end

    assign pr[r+1] = nxt;
  end

  assign rem_o = pr[Q][N-1:0];

  always_comb begin
    if (dvs_i == '0) begin
      // R5
      zero_dvs_chk: assert (quo_o == '1 && rem_o == dvd_i)
        else $error("zero divisor result wrong");
    end
    if (dvs_i != '0 && (dvd_i >> Q) < N'(dvs_i)) begin
      // R8
      rem_below_dvs_chk: assert (rem_o < N'(dvs_i))
        else $error("remainder not below divisor");
    end
  end

endmodule

// File: tb/restore_div_array_bench.sv
module restore_div_array_bench;

  logic clk;
  logic rst_n;
  int   nchecks;
  int   nfail;
  bit   done;

  // Narrow configuration: N=5, M=3, quotient 3 bits
  logic [4:0] a5;
  logic [2:0] b5;
  logic [2:0] q5;
  logic [4:0] r5;

  // Wide configuration: N=12, M=5, quotient 8 bits
  logic [11:0] a12;
  logic [4:0]  b12;
  logic [7:0]  q12;
  logic [11:0] r12;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  restore_div_array #(.N(5), .M(3)) u_restore_div_array (
    .dvd_i (a5),
    .dvs_i (b5),
    .quo_o (q5),
    .rem_o (r5)
  );

  restore_div_array #(.N(12), .M(5)) u_restore_div_array_wide (
    .dvd_i (a12),
    .dvs_i (b12),
    .quo_o (q12),
    .rem_o (r12)
  );

  task automatic chk(input string req, input int act, input int exp_v);
    nchecks++;
    if (act != exp_v) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic drive5(input int a, input int b);
    @(negedge clk);
    a5 = 5'(a);
    b5 = 3'(b);
    @(posedge clk);
    #1;
  endtask

  task automatic drive12(input int a, input int b);
    @(negedge clk);
    a12 = 12'(a);
    b12 = 5'(b);
    @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchecks++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end

  initial begin : main
    nchecks = 0;
    nfail   = 0;
    done    = 1'b0;
    rst_n   = 1'b0;
    a5 = '0; b5 = '0; a12 = '0; b12 = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;

    // Initial state: all-zero inputs, zero divisor rule (R5)
    chk("R5 initial quotient", int'(q5), 7);
    chk("R5 initial remainder", int'(r5), 0);

    // Worked examples
    drive5(17, 3);
    chk("R6 quotient", int'(q5), 5);
    chk("R6 remainder", int'(r5), 2);
    drive5(27, 4);
    chk("R7 quotient", int'(q5), 6);
    chk("R7 remainder", int'(r5), 3);

    // Exhaustive sweep of the narrow array
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 8; b++) begin
        drive5(a, b);
        if (b == 0) begin
          chk("R5 zero divisor quotient", int'(q5), 7);
          chk("R5 zero divisor remainder", int'(r5), a);
        end else if ((a >> 3) < b) begin
          if (b >= 4) begin
            chk("R9 quotient", int'(q5), a / b);
            chk("R9 remainder", int'(r5), a % b);
          end else begin
            chk("R1 quotient", int'(q5), a / b);
            chk("R2 remainder", int'(r5), a % b);
          end
          // R3 R4: bottom row bit set means the last subtraction was kept
          chk("R3/R4 bottom quotient bit", int'(q5[0]), (a / b) % 2);
          chk("R8 remainder below divisor", int'(r5 < 5'(b)), 1);
        end
      end
    end

    // Wide array: boundary values then pseudo-random pairs in range
    drive12(4095, 31);
    chk("R9 wide max quotient", int'(q12), 4095 / 31);
    chk("R9 wide max remainder", int'(r12), 4095 % 31);
    drive12(255, 1);
    chk("R1 wide quotient divisor one", int'(q12), 255);
    chk("R2 wide remainder divisor one", int'(r12), 0);
    drive12(3000, 0);
    chk("R5 wide zero divisor quotient", int'(q12), 255);
    chk("R5 wide zero divisor remainder", int'(r12), 3000);

    for (int i = 0; i < 2000; i++) begin
      int a;
      int b;
      b = int'($urandom_range(31, 1));
      a = int'($urandom_range(4095, 0));
      if ((a >> 8) >= b) a = a % (b * 256);
      drive12(a, b);
      chk("R1 wide quotient", int'(q12), a / b);
      chk("R2 wide remainder", int'(r12), a % b);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

endmodule